// File: doc/BRIEF.md
# Oversampled serial receiver with ninth-bit address filtering

This block is the receive side of a classic 8-bit-controller style asynchronous serial port. A separate baud generator supplies a single-cycle pulse at sixteen times the bit rate. The block synchronises the serial input line and watches it on every such pulse for a high-to-low edge. When it finds one, it restarts its sixteen-step phase counter, so that all later samples fall near the centre of each bit.

A frame has a low start bit and eight data bits, least significant first, followed by one more bit. With mode code 01 that bit is the stop bit. With mode codes 10 and 11 it is a programmable ninth bit, and a stop bit follows it. In every mode the ninth received bit is the final one examined, and it is reported on its own output. The shift register is preset to all ones when a start edge is found. The received word goes into a holding buffer only when the buffer is free and the address filter allows it. The filter passes a frame when filtering is off, or when filtering is on and the ninth bit is one. While one word waits in the buffer, the next word can already be assembled in the shift register.

Top module: `uart9_rx`

## Requirements
- R1: After reset, rx_flag, rx_byte and rx_bit9 are all zero.
- R2: A frame is received only if its start edge (high-to-low, seen between two consecutive oversample ticks) occurs while rx_en is 1 and mode is not 2'b00. A frame sent with rx_en at 0, or with mode 2'b00, leaves all three outputs unchanged.
- R3: The eight bits after the start bit form rx_byte, with the first received bit at bit 0. The next bit goes to rx_bit9. That bit is the stop bit for mode 2'b01 and the ninth bit for modes 2'b10 and 2'b11.
- R4: The tick on which the start edge is seen is count 0. Each bit's value is the majority of the line samples taken at counts 7, 8 and 9 of that bit period. A wrong value in any one of those three samples does not change the received bit.
- R5: If the start bit votes high, the receiver drops the frame and goes back to idle without loading anything. A frame that starts after this is received normally.
- R6: At the final bit, rx_byte, rx_bit9 and rx_flag are loaded only if rx_flag is 0 and either sm2 is 0 or the received ninth bit is 1. Otherwise the frame is discarded and the outputs keep their values.
- R7: A one-cycle flag_clr pulse while rx_flag is 1 clears rx_flag on the next cycle. rx_byte and rx_bit9 keep their values.
- R8: A frame can start while rx_flag is 1. rx_byte keeps the earlier word while the new frame is being assembled. If rx_flag is cleared before the new frame's final bit, the new frame is loaded.
- R9: While rx_flag is 1, rx_byte and rx_bit9 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial input; idles high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en | input | 1 | Allows new frames to start |
| mode | input | 2 | Frame mode: 01 = stop bit as ninth bit; 10 and 11 = nine data bits; 00 = receive off |
| sm2 | input | 1 | Address filter: when 1, only frames whose ninth bit is 1 are accepted |
| flag_clr | input | 1 | One-cycle pulse that clears rx_flag |
| rx_byte | output | 8 | Buffered data word |
| rx_bit9 | output | 1 | Buffered ninth bit (the stop bit in mode 01) |
| rx_flag | output | 1 | High while the buffer holds an unread word |

## Verification
The bench targets the filter decision in all combinations of filter bit, ninth bit and prior flag state. A design that inverted the filter, or ignored a pending flag, would load words that should be dropped or would lose words that should be kept. One frame carries single-sample glitches at count 8 of the start bit and several data bits. A receiver that decided on one sample would then return a corrupted word. Other directed cases cover the following:
- A short low pulse, which a receiver without the false-start check would turn into a bogus frame.
- A frame sent while the receiver is disabled or in mode 00.
- A flag clear issued in the middle of a frame. A design that had no separate shift register, or that checked the flag at the start of the frame instead of at its end, would corrupt or reject the overlapping word.

// File: rtl/uart9_rx_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the 9-bit serial receiver.
// Assumes nothing beyond standard SystemVerilog.
package uart9_rx_pkg;

    // Frame controller state
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    // Two-out-of-three majority
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart9_rx_sync.sv
`timescale 1ns/1ps
// Module: uart9_rx_sync
// Brings the asynchronous serial line into the clock domain through a chain
// of STAGES flops. Resets to the idle (high) level, so a line that is low
// during reset is not taken as an edge.
module uart9_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= din;
            end
        end else begin : g_multi
            // Shift the line through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart9_rx_sampler.sv
`timescale 1ns/1ps
// Module: uart9_rx_sampler
// Phase counter over OSR oversample ticks, with a three-sample majority vote
// around the bit centre. The tick carrying `restart` is count 0. Samples are
// taken at counts MID-1, MID and MID+1. The decision is strobed on the
// MID+1 tick. Assumes OSR is a power of two, so the counter wraps by itself.
module uart9_rx_sampler
    import uart9_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic line,
    output logic bit_stb,
    output logic bit_val
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] P_EARLY = CW'(MID - 1);
    localparam logic [CW-1:0] P_MID   = CW'(MID);
    localparam logic [CW-1:0] P_LATE  = CW'(MID + 1);

    logic [CW-1:0] phase;
    logic          smp_early;
    logic          smp_mid;

    // Phase counter: the restart tick is count 0, so the next tick is count 1
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= restart ? CW'(1) : phase + 1'b1;
    end

    // Capture the two early samples of the vote
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_early <= 1'b1;
            smp_mid   <= 1'b1;
        end else if (tick) begin
            if (phase == P_EARLY) smp_early <= line;
            if (phase == P_MID)   smp_mid   <= line;
        end
    end

    assign bit_stb = tick && !restart && (phase == P_LATE);
    assign bit_val = vote3(smp_early, smp_mid, line);
endmodule

// File: rtl/uart9_rx_ctrl.sv
`timescale 1ns/1ps
// Module: uart9_rx_ctrl
// Frame controller. It detects the start edge on oversample ticks, rejects
// false starts, shifts in DATA_W data bits (LSB first) plus one ninth bit,
// applies the address filter and loads the holding buffer. The shift
// register is separate from the buffer, so one word can be assembled while
// the previous one is unread. Assumes bit_stb arrives once per bit period.
module uart9_rx_ctrl
    import uart9_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_en,
    input  logic [1:0]        mode,
    input  logic              sm2,
    input  logic              flag_clr,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              start,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag
);
    localparam int IW = $clog2(DATA_W + 2);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W + 1);

    rx_state_e         state;
    logic [IW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              line_prev;
    logic              final_stb;
    logic              accept;

    // Remember the line level at the previous tick, for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)    line_prev <= 1'b1;
        else if (tick) line_prev <= line;
    end

    assign start     = (state == RX_IDLE) && tick && line_prev && !line
                       && rx_en && (mode != 2'b00);
    assign final_stb = (state == RX_BUSY) && bit_stb && (bit_idx == IDX_LAST);
    assign accept    = final_stb && !rx_flag && (!sm2 || bit_val);

    // Frame sequencing: start check, data shifting, return to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            bit_idx <= '0;
            shreg   <= '1;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (start) begin
                        state   <= RX_BUSY;
                        bit_idx <= '0;
                        shreg   <= '1;
                    end
                end
                RX_BUSY: begin
                    if (bit_stb) begin
                        if (bit_idx == '0) begin
                            if (bit_val) state   <= RX_IDLE;
                            else         bit_idx <= IW'(1);
                        end else if (bit_idx == IDX_LAST) begin
                            state <= RX_IDLE;
                        end else begin
                            shreg   <= {bit_val, shreg[DATA_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Holding buffer and receive flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_bit9 <= 1'b0;
            rx_flag <= 1'b0;
        end else if (accept) begin
            rx_byte <= shreg;
            rx_bit9 <= bit_val;
            rx_flag <= 1'b1;
        end else if (flag_clr) begin
            rx_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/uart9_rx.sv
`timescale 1ns/1ps
// Module: uart9_rx (top)
// Receiver for 10-bit and 11-bit asynchronous frames with ninth-bit address
// filtering. The caller supplies a tick at OSR times the bit rate. All
// control inputs are assumed synchronous to clk. Reset is synchronous and
// active low.
module uart9_rx #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              os_tick,
    input  logic              rx_en,
    input  logic [1:0]        mode,
    input  logic              sm2,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_flag
);
    logic line_s;
    logic start;
    logic bit_stb;
    logic bit_val;

    uart9_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (line_s)
    );

    uart9_rx_sampler #(.OSR(OSR)) sampler_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .restart (start),
        .line    (line_s),
        .bit_stb (bit_stb),
        .bit_val (bit_val)
    );

    uart9_rx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .line     (line_s),
        .rx_en    (rx_en),
        .mode     (mode),
        .sm2      (sm2),
        .flag_clr (flag_clr),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .start    (start),
        .rx_byte  (rx_byte),
        .rx_bit9  (rx_bit9),
        .rx_flag  (rx_flag)
    );
endmodule

// File: rtl/uart9_rx_chk.sv
`timescale 1ns/1ps
// Module: uart9_rx_chk
// Checker attached to uart9_rx by bind. It watches the buffer and flag
// outputs against the filter and flag-clear inputs.
module uart9_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sm2,
    input logic              flag_clr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_bit9,
    input logic              rx_flag
);
    AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && rx_flag) |=> !rx_flag); // R7

    AST_BUFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flag |=> ($stable(rx_byte) && $stable(rx_bit9))); // R9

    AST_LOAD_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rx_byte) || !$stable(rx_bit9)) |-> $rose(rx_flag)); // R6

    AST_FILTER_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_flag) && $past(sm2)) |-> rx_bit9); // R6
endmodule

bind uart9_rx uart9_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sm2      (sm2),
    .flag_clr (flag_clr),
    .rx_byte  (rx_byte),
    .rx_bit9  (rx_bit9),
    .rx_flag  (rx_flag)
);

// File: tb/uart9_rx_tb_top.sv
`timescale 1ns/1ps
// Bench for uart9_rx: a table of frames walked by one loop, then directed
// cases for reset, enable gating, false start, glitch voting and overlap.
module uart9_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OSR        = 16;
    localparam int NVEC       = 10;

    // {mode[1:0], sm2, clear_first, data[7:0], ninth, expect_accept}
    localparam logic [13:0] VECS [0:NVEC-1] = '{
        {2'd1, 1'b0, 1'b1, 8'hA5, 1'b1, 1'b1},
        {2'd1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b1, 8'h0F, 1'b0, 1'b0},
        {2'd1, 1'b1, 1'b1, 8'hF0, 1'b1, 1'b1},
        {2'd2, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1},
        {2'd3, 1'b1, 1'b1, 8'h7E, 1'b0, 1'b0},
        {2'd3, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1},
        {2'd2, 1'b0, 1'b0, 8'h55, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {2'd3, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_en = 1'b1;
    logic [1:0] mode = 2'd1;
    logic       sm2 = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_flag;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv  = 0;
    bit done  = 1'b0;

    logic [7:0] exp_byte;
    logic       exp_b9;
    logic       exp_flag;

    uart9_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .rx_en(rx_en), .mode(mode), .sm2(sm2), .flag_clr(flag_clr),
        .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_flag(rx_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Oversample tick: one cycle in every TICK_DIV, changed on the falling edge
    always @(negedge clk) begin
        os_tick <= (tdiv == TICK_DIV - 1);
        tdiv    <= (tdiv + 1) % TICK_DIV;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag, input logic f, input logic [7:0] b, input logic n9);
        check({tag, " flag"}, int'(rx_flag), int'(f));
        check({tag, " byte"}, int'(rx_byte), int'(b));
        check({tag, " ninth"}, int'(rx_bit9), int'(n9));
    endtask

    // Return at the falling edge just after the next tick
    task automatic wait_tick();
        @(posedge clk);
        while (os_tick !== 1'b1) @(posedge clk);
        @(negedge clk);
    endtask

    // One bit period; an optional glitch covers only the count-8 sample
    task automatic send_bit(input logic v, input logic glitch);
        rxd = v;
        for (int i = 1; i <= OSR; i++) begin
            wait_tick();
            if (glitch && i == 8) rxd = ~v;
            if (glitch && i == 9) rxd = v;
        end
    endtask

    // gmask bit 0: start; bits 1..8: data; bit 9: ninth
    task automatic send_frame(input logic [7:0] d, input logic n9, input logic [9:0] gmask);
        wait_tick();
        send_bit(1'b0, gmask[0]);
        for (int k = 0; k < 8; k++) send_bit(d[k], gmask[k+1]);
        send_bit(n9, gmask[9]);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_out("R1 reset", 1'b0, 8'h00, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R1 after release", 1'b0, 8'h00, 1'b0);

        // Table walk: R3 frame assembly, R6 address filter
        exp_flag = 1'b0; exp_byte = 8'h00; exp_b9 = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            mode = VECS[v][13:12];
            sm2  = VECS[v][11];
            if (VECS[v][10]) begin
                pulse_clr();
                exp_flag = 1'b0;
            end
            send_frame(VECS[v][9:2], VECS[v][1], 10'b0);
            if (VECS[v][0]) begin
                exp_flag = 1'b1;
                exp_byte = VECS[v][9:2];
                exp_b9   = VECS[v][1];
            end
            check_out($sformatf("R3/R6 vec%0d", v), exp_flag, exp_byte, exp_b9);
        end

        // R2: disabled receiver ignores a frame
        sm2 = 1'b0; mode = 2'd1;
        pulse_clr();
        rx_en = 1'b0;
        send_frame(8'h12, 1'b1, 10'b0);
        check_out("R2 rx_en low", 1'b0, 8'hFF, 1'b1);
        // R2: mode 00 ignores a frame
        rx_en = 1'b1; mode = 2'd0;
        send_frame(8'h34, 1'b1, 10'b0);
        check_out("R2 mode 00", 1'b0, 8'hFF, 1'b1);
        mode = 2'd1;

        // R5: short low pulse is a false start; next frame still received
        wait_tick();
        rxd = 1'b0;
        repeat (4) wait_tick();
        rxd = 1'b1;
        repeat (2 * OSR) wait_tick();
        check_out("R5 false start", 1'b0, 8'hFF, 1'b1);
        send_frame(8'h96, 1'b1, 10'b0);
        check_out("R5 frame after false start", 1'b1, 8'h96, 1'b1);

        // R4: single-sample glitches at count 8 do not alter bits
        pulse_clr();
        send_frame(8'h5A, 1'b1, 10'b10_0101_0011);
        check_out("R4 majority vote", 1'b1, 8'h5A, 1'b1);

        // R8: new frame overlaps an unread word; clear arrives mid-frame
        fork
            send_frame(8'h3C, 1'b1, 10'b0);
            begin
                repeat (5 * OSR) wait_tick();
                check("R8 old word held mid-frame", int'(rx_byte), 32'h5A);
                pulse_clr();
            end
        join
        check_out("R8 overlapped frame loaded", 1'b1, 8'h3C, 1'b1);

        // R9: a frame finishing while the flag is set leaves the buffer alone
        send_frame(8'h11, 1'b0, 10'b0);
        check_out("R9 buffer held", 1'b1, 8'h3C, 1'b1);

        // R7: clear drops the flag and keeps the data
        pulse_clr();
        check_out("R7 flag cleared", 1'b0, 8'h3C, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule